// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one accepted burst request into the stream of column addresses that an SDRAM controller drives during a read or write burst inside an already open row. It takes the programmed mode fields and a starting column. The mode fields are a 3-bit length code, an ordering bit and a single-write bit. From these it emits one column per clock, a beat-valid strobe, a final-beat marker and a flag for mode settings that the burst rules forbid.

The length and ordering are captured when a request is accepted, so later changes on the mode inputs leave a running burst alone. The ordering is either sequential (the low bits wrap inside an aligned block) or interleaved (the low bits are the start bits XOR the beat number). In full-page mode the address walks the whole row, wrapping at the row size, until a stop strobe arrives. The stop strobe also cuts short any fixed-length burst. When the single-write bit is set, a write request becomes a single-location access, while reads keep the programmed length. Command timing, banks, rows, CAS latency and data are handled elsewhere.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `beat_vld_o`, `last_o` and `bad_mode_o` all low, and any running burst is abandoned.
- R2: The length code on `len_code_i` sets the beat count of a read: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page (2**COL_W columns, 256 by default).
- R3: With `order_i`=0 (sequential), beat i carries the start column with its low log2(length) bits replaced by (start low bits + i) modulo the length; the upper bits stay as in the start column.
- R4: With `order_i`=1 (interleaved), beat i carries the start column with its low log2(length) bits replaced by (start low bits XOR i).
- R5: A full-page burst steps the column up by one per beat, wraps from 2**COL_W-1 to 0, and runs until it is stopped.
- R6: When `stop_i` is high at a rising edge during a burst, the beat shown after that edge is the final one and carries `last_o`=1. No further beat follows.
- R7: `last_o` is high only together with `beat_vld_o`. In a fixed-length burst that is not stopped, it is high exactly on the beat numbered length-1.
- R8: A write (`is_write_i`=1) with `wr_single_i`=1 yields exactly one beat. A read with `wr_single_i`=1, or a write with `wr_single_i`=0, keeps the programmed length.
- R9: Length codes 3'b100 to 3'b110, or code 3'b111 with `order_i`=1, are illegal. `bad_mode_o` shows this one cycle after the inputs present it, and a start under an illegal mode produces no beat.
- R10: A start strobe that arrives while a burst is running is ignored. Mode and column inputs matter only at the edge where a start is accepted.
- R11: The first beat appears in the cycle after the edge that accepts the start. Beats are contiguous. A start given during the final-beat cycle is accepted, so the next burst follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a burst, sampled when idle |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| wr_single_i | input | 1 | 1 = writes access one location only |
| stop_i | input | 1 | Burst terminate strobe |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Current beat is the final one |
| bad_mode_o | output | 1 | Mode inputs form an illegal combination |

## Verification
Two end conditions can land on the same edge: a stop strobe that arrives just as a fixed-length burst reaches its natural final beat, and a new start that arrives in the final-beat cycle of the previous burst. The bench raises the stop one cycle before beat three of a four-beat burst and expects exactly one final-beat marker and no extra beat. It also drives a start while the eighth beat of a burst is on the outputs and expects the new start column in the very next cycle.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } len_code_e;

  // true when the length code / ordering pair is not allowed
  function automatic logic mode_is_illegal(input logic [2:0] code, input logic inter);
    logic res;
    case (code)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT: res = 1'b0;
      LEN_PAGE: res = inter;
      default:  res = 1'b1;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sdrb_mode_decode.sv
module sdrb_mode_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code,
  input  logic             inter,
  input  logic             is_write,
  input  logic             wr_single,
  output logic [COL_W-1:0] len_m1,
  output logic             full_page,
  output logic             illegal
);

  logic [COL_W-1:0] base_m1;

  always_comb begin
    full_page = 1'b0;
    case (len_code)
      LEN_TWO:   base_m1 = COL_W'(1);
      LEN_FOUR:  base_m1 = COL_W'(3);
      LEN_EIGHT: base_m1 = COL_W'(7);
      LEN_PAGE: begin
        base_m1   = '1;
        full_page = 1'b1;
      end
      default:   base_m1 = '0;
    endcase
    illegal = mode_is_illegal(len_code, inter);
    if (is_write && wr_single) begin
      len_m1    = '0;
      full_page = 1'b0;
    end else begin
      len_m1 = base_m1;
    end
  end

endmodule

// File: rtl/sdrb_addr_unit.sv
module sdrb_addr_unit #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             inter,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] xor_low;

  assign seq_low = base + idx;
  assign xor_low = base ^ idx;

  // mask bits select the moving part, the rest keeps the start column
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? (inter ? xor_low[b] : seq_low[b]) : base[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_i,
  input  logic             wr_single_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             last_o,
  output logic             bad_mode_o
);

  logic [COL_W-1:0] dec_len_m1;
  logic             dec_full;
  logic             dec_bad;

  logic             busy_q;
  logic             full_q;
  logic             inter_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] next_col;
  logic             end_now;

  sdrb_mode_decode #(.COL_W(COL_W)) dec_i (
    .len_code  (len_code_i),
    .inter     (order_i),
    .is_write  (is_write_i),
    .wr_single (wr_single_i),
    .len_m1    (dec_len_m1),
    .full_page (dec_full),
    .illegal   (dec_bad)
  );

  sdrb_addr_unit #(.COL_W(COL_W)) addr_i (
    .base  (base_q),
    .idx   (cnt_q),
    .mask  (mask_q),
    .inter (inter_q),
    .col   (next_col)
  );

  assign end_now = stop_i || (!full_q && (cnt_q == mask_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      full_q     <= 1'b0;
      inter_q    <= 1'b0;
      mask_q     <= '0;
      base_q     <= '0;
      cnt_q      <= '0;
      col_o      <= '0;
      beat_vld_o <= 1'b0;
      last_o     <= 1'b0;
      bad_mode_o <= 1'b0;
    end else begin
      bad_mode_o <= dec_bad;
      if (busy_q) begin
        col_o      <= next_col;
        beat_vld_o <= 1'b1;
        last_o     <= end_now;
        busy_q     <= !end_now;
        cnt_q      <= cnt_q + COL_W'(1);
      end else if (start_i && !dec_bad) begin
        base_q     <= start_col_i;
        mask_q     <= dec_len_m1;
        full_q     <= dec_full;
        inter_q    <= order_i;
        cnt_q      <= COL_W'(1);
        col_o      <= start_col_i;
        beat_vld_o <= 1'b1;
        last_o     <= (dec_len_m1 == '0);
        busy_q     <= (dec_len_m1 != '0);
      end else begin
        beat_vld_o <= 1'b0;
        last_o     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [2:0]       len_code_i,
  input logic             order_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             last_o,
  input logic             busy_q,
  input logic             full_q
);

  logic bad_in;
  assign bad_in = (len_code_i inside {3'b100, 3'b101, 3'b110}) ||
                  (len_code_i == 3'b111 && order_i);

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!beat_vld_o && !last_o));

  // R7
  last_with_beat_chk: assert property (@(posedge clk) disable iff (rst)
    !beat_vld_o |-> !last_o);

  // R11
  beats_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !last_o) |=> beat_vld_o);

  // R6
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !last_o && stop_i) |=> (beat_vld_o && last_o));

  // R5
  page_step_chk: assert property (@(posedge clk) disable iff (rst)
    (full_q && beat_vld_o && !last_o) |=> (col_o == $past(col_o) + COL_W'(1)));

  // R9
  illegal_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q && bad_in) |=> !beat_vld_o);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .len_code_i (len_code_i),
  .order_i    (order_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .beat_vld_o (beat_vld_o),
  .last_o     (last_o),
  .busy_q     (busy_q),
  .full_q     (full_q)
);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;
  localparam int NVEC = 14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             is_write_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = 3'b000;
  logic             order_i = 1'b0;
  logic             wr_single_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o;
  logic             last_o;
  logic             bad_mode_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i), .order_i(order_i),
    .wr_single_i(wr_single_i), .stop_i(stop_i), .col_o(col_o),
    .beat_vld_o(beat_vld_o), .last_o(last_o), .bad_mode_o(bad_mode_o)
  );

  // fields: code[3] order[1] write[1] single[1] col[8] stop_at[9]  (stop_at 0 = none)
  localparam logic [22:0] TBL [NVEC] = '{
    {3'b000, 1'b0, 1'b0, 1'b0, 8'h35, 9'd0},   // R2 one beat
    {3'b001, 1'b0, 1'b0, 1'b0, 8'h35, 9'd0},   // R2 R3 two beats wrap
    {3'b010, 1'b0, 1'b0, 1'b0, 8'h36, 9'd0},   // R3 four
    {3'b011, 1'b0, 1'b0, 1'b0, 8'h1D, 9'd0},   // R3 eight
    {3'b010, 1'b1, 1'b0, 1'b0, 8'h35, 9'd0},   // R4 four interleaved
    {3'b011, 1'b1, 1'b0, 1'b0, 8'h1D, 9'd0},   // R4 eight interleaved
    {3'b011, 1'b0, 1'b1, 1'b0, 8'h40, 9'd0},   // R8 write full length
    {3'b011, 1'b0, 1'b1, 1'b1, 8'h40, 9'd0},   // R8 write single
    {3'b011, 1'b0, 1'b0, 1'b1, 8'h40, 9'd0},   // R8 read keeps length
    {3'b011, 1'b0, 1'b0, 1'b0, 8'h42, 9'd3},   // R6 early stop
    {3'b111, 1'b0, 1'b0, 1'b0, 8'hFC, 9'd6},   // R5 page wrap
    {3'b101, 1'b0, 1'b0, 1'b0, 8'h10, 9'd0},   // R9 reserved code
    {3'b111, 1'b1, 1'b0, 1'b0, 8'h10, 9'd0},   // R9 page with interleave
    {3'b010, 1'b0, 1'b0, 1'b0, 8'h20, 9'd3}    // R6 R7 stop on natural last
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_col(input int start, input int idx, input int m1, input bit inter);
    int low;
    low = inter ? ((start ^ idx) & m1) : ((start + idx) & m1);
    return (start & ~m1 & 255) | low;
  endfunction

  task automatic run_vec(input logic [2:0] code, input bit ord, input bit wr, input bit sgl,
                         input int col, input int stop_at);
    bit illegal;
    bit page;
    int m1;
    int fin;
    illegal = (code >= 3'b100 && code <= 3'b110) || (code == 3'b111 && ord);
    page = (code == 3'b111) && !(wr && sgl);
    case (code)
      3'b001: m1 = 1;
      3'b010: m1 = 3;
      3'b011: m1 = 7;
      3'b111: m1 = 255;
      default: m1 = 0;
    endcase
    if (wr && sgl) m1 = 0;
    if (page) fin = stop_at;
    else if (stop_at != 0 && stop_at < m1) fin = stop_at;
    else fin = m1;

    @(negedge clk);
    start_i = 1'b1; len_code_i = code; order_i = ord; is_write_i = wr;
    wr_single_i = sgl; start_col_i = col[COL_W-1:0]; stop_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    if (illegal) begin
      chk(bad_mode_o == 1'b1, "R9 flag", bad_mode_o, 1);
      for (int k = 0; k < 3; k++) begin
        chk(beat_vld_o == 1'b0, "R9 no beat", beat_vld_o, 0);
        @(negedge clk);
      end
      return;
    end
    chk(bad_mode_o == 1'b0, "R9 legal flag", bad_mode_o, 0);
    for (int i = 0; i <= fin; i++) begin
      chk(beat_vld_o == 1'b1, "R11 beat valid", beat_vld_o, 1);
      chk(int'(col_o) == model_col(col, i, m1, ord), ord ? "R4 column" : (page ? "R5 column" : "R3 column"),
          col_o, model_col(col, i, m1, ord));
      chk(last_o == (i == fin), "R7 last flag", last_o, (i == fin));
      stop_i = (i + 1 == stop_at);
      if (i < fin) @(negedge clk);
    end
    stop_i = 1'b0;
    @(negedge clk);
    chk(beat_vld_o == 1'b0, "R2 beat count end", beat_vld_o, 0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(beat_vld_o == 1'b0 && last_o == 1'b0 && bad_mode_o == 1'b0, "R1 reset state",
        {beat_vld_o, last_o, bad_mode_o}, 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++)
      run_vec(TBL[v][22:20], TBL[v][19], TBL[v][18], TBL[v][17], int'(TBL[v][16:9]), int'(TBL[v][8:0]));

    // R5 long page run wrapping past the row end
    run_vec(3'b111, 1'b0, 1'b0, 1'b0, 8'h10, 260);

    // R10 start and mode change during a burst are ignored; R11 back-to-back
    @(negedge clk);
    start_i = 1'b1; len_code_i = 3'b011; order_i = 1'b0; is_write_i = 1'b0;
    wr_single_i = 1'b0; start_col_i = 8'h40;
    @(negedge clk);
    start_i = 1'b1; len_code_i = 3'b000; order_i = 1'b1; start_col_i = 8'h00;
    for (int i = 0; i < 8; i++) begin
      chk(beat_vld_o && int'(col_o) == 8'h40 + i, "R10 busy start ignored", col_o, 8'h40 + i);
      chk(last_o == (i == 7), "R10 length kept", last_o, (i == 7));
      if (i == 1) start_i = 1'b0;
      if (i == 7) begin
        start_i = 1'b1; len_code_i = 3'b001; order_i = 1'b0; start_col_i = 8'h80;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(beat_vld_o && col_o == 8'h80 && !last_o, "R11 back-to-back first", col_o, 8'h80);
    @(negedge clk);
    chk(beat_vld_o && col_o == 8'h81 && last_o, "R11 back-to-back last", col_o, 8'h81);
    @(negedge clk);
    chk(!beat_vld_o, "R11 idle after", beat_vld_o, 0);

    // R1 reset during a burst
    start_i = 1'b1; len_code_i = 3'b011; start_col_i = 8'h08;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!beat_vld_o && !last_o && !bad_mode_o, "R1 mid-burst reset", beat_vld_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!beat_vld_o, "R1 burst abandoned", beat_vld_o, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule